// File: doc/BRIEF.md
# Pop-all register restore sequencer

This block reloads the eight general-purpose registers of a processor core from stack memory after a single start command. Once the command is accepted it reads eight consecutive stack slots, one read per clock, from a synchronous-read stack memory. Each returned word goes out through a register-file write port. The slot where the stack pointer was saved is read but never written back. Instead, the new stack pointer is delivered as the start value advanced by eight slots.

Two operand sizes are supported: 2-byte slots, which update only the low half of each register, and 4-byte slots, which update the full register. The block checks the command before it touches any state. A command flagged as coming from 64-bit mode, or one that carries a lock prefix, ends with an invalid-opcode status. A command whose first or last stack byte lies beyond the stack segment limit ends with a stack-fault status. A rejected command issues no reads, no register writes and no stack-pointer update.

Top module: `gpr_restore_seq`

## Requirements
- R1: After reset, busy, done, mem_rd_en, rf_we and sp_we are all 0.
- R2: Consider a start accepted at clock edge E0. The block issues stack reads after edges E0 through E0+7, one per cycle. Read k uses address sp_in + k*S, where S is 4 when op32=1 and 2 when op32=0. Memory words are little-endian, with the byte at the read address in bits 7:0.
- R3: Register indices are AX=0, CX=1, DX=2, BX=3, SP=4, BP=5, SI=6, DI=7. The data of read k is written to index 7-k, with rf_we high in the cycle after edge E0+k+2. Read 3 (index 4) is discarded, so the write order is 7, 6, 5, 3, 2, 1, 0.
- R4: With op32=1, rf_wmask is 4'b1111 and rf_wdata carries all four bytes. With op32=0, rf_wmask is 4'b0011 and rf_wdata carries the two bytes, with bits 31:16 zero.
- R5: On a successful command, done and sp_we are high for exactly one cycle, after edge E0+10, one cycle after the last write. At that point status=0 and sp_wdata=(sp_in+8*S) mod 2^ADDR_W.
- R6: A start with mode64=1 gives done after edge E0+1 with status=1 (invalid opcode), and no reads, writes or sp_we.
- R7: A start with lock=1 behaves as in R6, with status=1.
- R8: If sp_in > seg_limit, or if sp_in+8*S-1 (computed without wrap) > seg_limit, the block gives done after edge E0+1 with status=2 (stack fault), and no reads, writes or sp_we.
- R9: When the invalid-opcode condition and the stack-fault condition both hold, status is 1.
- R10: A start that arrives while busy=1 is ignored, and the running command completes unchanged.
- R11: For a successful command, busy is high from after E0 through after E0+9, and low with done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command strobe, sampled while idle |
| op32 | input | 1 | 1 selects 4-byte slots, 0 selects 2-byte slots |
| mode64 | input | 1 | Core is in 64-bit mode (command invalid) |
| lock | input | 1 | Command carries a lock prefix (invalid) |
| sp_in | input | ADDR_W | Stack pointer at command start |
| seg_limit | input | ADDR_W | Highest valid stack byte address |
| busy | output | 1 | Command in progress |
| mem_rd_en | output | 1 | Stack read request |
| mem_addr | output | ADDR_W | Stack read byte address |
| mem_rdata | input | REG_W | Read data, valid one cycle after the request |
| rf_we | output | 1 | Register-file write enable |
| rf_idx | output | 3 | Register-file write index |
| rf_wdata | output | REG_W | Register-file write data |
| rf_wmask | output | REG_W/8 | Byte enables for the write |
| sp_we | output | 1 | Stack-pointer update strobe |
| sp_wdata | output | ADDR_W | New stack pointer |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 ok, 1 invalid opcode, 2 stack fault |

## Verification
The bench applies each stimulus at the falling clock edge and counts falling edges from the edge that accepts the start. It expects reads at counts 0 through 7, writes at counts 2 through 9 except count 5, and done with the stack-pointer update at count 10. A rejected command instead shows done at count 1. Every output is compared at every count of a 14-cycle window, so a result that arrives one cycle early or late, or an extra pulse after completion, counts as a failure. The main sweep covers every start address of an 8-bit stack for both slot sizes and two segment limits, which exercises the limit boundary and address wrap.

// File: rtl/grs_pkg.sv
package grs_pkg;
  typedef enum logic [1:0] {
    ST_OK    = 2'd0,
    ST_BADOP = 2'd1,
    ST_STACK = 2'd2
  } grs_status_e;

  localparam int unsigned SLOT_CNT  = 8;
  localparam int unsigned SKIP_SLOT = 3;
  localparam int unsigned IDX_W     = 3;
endpackage

// File: rtl/grs_limit_chk.sv
module grs_limit_chk
  import grs_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned REG_W  = 32
) (
  input  logic [ADDR_W-1:0] sp,
  input  logic [ADDR_W-1:0] limit,
  input  logic              wide,
  input  logic              is64,
  input  logic              lock_pfx,
  output grs_status_e       verdict
);
  localparam int unsigned BYTES     = REG_W / 8;
  localparam int unsigned SPAN_WIDE = SLOT_CNT * BYTES;
  localparam int unsigned SPAN_NARR = SLOT_CNT * (BYTES / 2);

  logic [ADDR_W:0] last_byte;

  // last byte touched, one extra bit so a wrap past the top is caught
  always_comb begin
    last_byte = {1'b0, sp} + (wide ? (ADDR_W+1)'(SPAN_WIDE) : (ADDR_W+1)'(SPAN_NARR))
                - (ADDR_W+1)'(1);
    if (is64 || lock_pfx)
      verdict = ST_BADOP;
    else if ((sp > limit) || (last_byte > {1'b0, limit}))
      verdict = ST_STACK;
    else
      verdict = ST_OK;
  end
endmodule

// File: rtl/grs_ctrl.sv
module grs_ctrl
  import grs_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned REG_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              op32,
  input  logic              mode64,
  input  logic              lock_pfx,
  input  logic [ADDR_W-1:0] sp_in,
  input  logic [ADDR_W-1:0] seg_limit,
  input  logic              wb_last,
  output logic              busy,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [IDX_W-1:0]  rd_slot,
  output logic              wide,
  output logic [ADDR_W-1:0] base,
  output logic              flt_pulse,
  output grs_status_e       flt_code
);
  localparam int unsigned BYTES = REG_W / 8;

  typedef enum logic [1:0] {S_IDLE, S_READ, S_DRAIN} ctrl_st_e;

  ctrl_st_e          st;
  grs_status_e       verdict;
  logic [ADDR_W-1:0] step;

  assign step = wide ? ADDR_W'(BYTES) : ADDR_W'(BYTES / 2);

  grs_limit_chk #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_chk (
    .sp      (sp_in),
    .limit   (seg_limit),
    .wide    (op32),
    .is64    (mode64),
    .lock_pfx(lock_pfx),
    .verdict (verdict)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      busy      <= 1'b0;
      rd_en     <= 1'b0;
      rd_addr   <= '0;
      rd_slot   <= '0;
      wide      <= 1'b0;
      base      <= '0;
      flt_pulse <= 1'b0;
      flt_code  <= ST_OK;
    end else begin
      flt_pulse <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start) begin
            if (verdict != ST_OK) begin
              flt_pulse <= 1'b1;
              flt_code  <= verdict;
            end else begin
              st      <= S_READ;
              busy    <= 1'b1;
              rd_en   <= 1'b1;
              rd_addr <= sp_in;
              rd_slot <= '0;
              wide    <= op32;
              base    <= sp_in;
            end
          end
        end
        S_READ: begin
          if (rd_slot == IDX_W'(SLOT_CNT - 1)) begin
            rd_en <= 1'b0;
            st    <= S_DRAIN;
          end else begin
            rd_slot <= rd_slot + IDX_W'(1);
            rd_addr <= rd_addr + step;
          end
        end
        S_DRAIN: begin
          if (wb_last) begin
            st   <= S_IDLE;
            busy <= 1'b0;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R2: successive reads advance by one slot
  p_read_step_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_en && $past(rd_en)) |-> (rd_addr == $past(rd_addr) + step));

  // R11: reads only while the command is marked busy
  p_read_busy_r11: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> busy);
endmodule

// File: rtl/grs_wb.sv
module grs_wb
  import grs_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned REG_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_en,
  input  logic [IDX_W-1:0]   rd_slot,
  input  logic [REG_W-1:0]   mem_rdata,
  input  logic               wide,
  input  logic [ADDR_W-1:0]  base,
  input  logic               flt_pulse,
  input  grs_status_e        flt_code,
  output logic               rf_we,
  output logic [IDX_W-1:0]   rf_idx,
  output logic [REG_W-1:0]   rf_wdata,
  output logic [REG_W/8-1:0] rf_wmask,
  output logic               last_wr,
  output logic               sp_we,
  output logic [ADDR_W-1:0]  sp_wdata,
  output logic               done,
  output grs_status_e        status
);
  localparam int unsigned BYTES     = REG_W / 8;
  localparam int unsigned HALF      = REG_W / 2;
  localparam int unsigned SPAN_WIDE = SLOT_CNT * BYTES;
  localparam int unsigned SPAN_NARR = SLOT_CNT * (BYTES / 2);

  logic              v1;
  logic [IDX_W-1:0]  s1;
  logic [REG_W-1:0]  data_sel;
  logic [BYTES-1:0]  mask_sel;

  always_comb begin
    data_sel = wide ? mem_rdata : {{HALF{1'b0}}, mem_rdata[HALF-1:0]};
    mask_sel = wide ? {BYTES{1'b1}} : {{(BYTES/2){1'b0}}, {(BYTES/2){1'b1}}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v1       <= 1'b0;
      s1       <= '0;
      rf_we    <= 1'b0;
      rf_idx   <= '0;
      rf_wdata <= '0;
      rf_wmask <= '0;
      last_wr  <= 1'b0;
      sp_we    <= 1'b0;
      sp_wdata <= '0;
      done     <= 1'b0;
      status   <= ST_OK;
    end else begin
      v1      <= rd_en;
      s1      <= rd_slot;
      rf_we   <= v1 && (s1 != IDX_W'(SKIP_SLOT));
      last_wr <= v1 && (s1 == IDX_W'(SLOT_CNT - 1));
      if (v1) begin
        rf_idx   <= IDX_W'(SLOT_CNT - 1) - s1;
        rf_wdata <= data_sel;
        rf_wmask <= mask_sel;
      end
      done  <= last_wr || flt_pulse;
      sp_we <= last_wr;
      if (last_wr) begin
        sp_wdata <= base + (wide ? ADDR_W'(SPAN_WIDE) : ADDR_W'(SPAN_NARR));
        status   <= ST_OK;
      end else if (flt_pulse) begin
        status <= flt_code;
      end
    end
  end

  // R3: the saved stack-pointer slot never reaches the register file
  p_skip_slot_r3: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> (rf_idx != IDX_W'(SLOT_CNT - 1 - SKIP_SLOT)));

  // R5: stack pointer is only updated on a clean completion
  p_sp_ok_r5: assert property (@(posedge clk) disable iff (rst)
    sp_we |-> (done && status == ST_OK));
endmodule

// File: rtl/gpr_restore_seq.sv
module gpr_restore_seq
  import grs_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned REG_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               op32,
  input  logic               mode64,
  input  logic               lock,
  input  logic [ADDR_W-1:0]  sp_in,
  input  logic [ADDR_W-1:0]  seg_limit,
  output logic               busy,
  output logic               mem_rd_en,
  output logic [ADDR_W-1:0]  mem_addr,
  input  logic [REG_W-1:0]   mem_rdata,
  output logic               rf_we,
  output logic [2:0]         rf_idx,
  output logic [REG_W-1:0]   rf_wdata,
  output logic [REG_W/8-1:0] rf_wmask,
  output logic               sp_we,
  output logic [ADDR_W-1:0]  sp_wdata,
  output logic               done,
  output logic [1:0]         status
);
  logic              wb_last;
  logic [IDX_W-1:0]  rd_slot;
  logic              wide;
  logic [ADDR_W-1:0] base;
  logic              flt_pulse;
  grs_status_e       flt_code;
  grs_status_e       status_e;

  grs_ctrl #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .op32     (op32),
    .mode64   (mode64),
    .lock_pfx (lock),
    .sp_in    (sp_in),
    .seg_limit(seg_limit),
    .wb_last  (wb_last),
    .busy     (busy),
    .rd_en    (mem_rd_en),
    .rd_addr  (mem_addr),
    .rd_slot  (rd_slot),
    .wide     (wide),
    .base     (base),
    .flt_pulse(flt_pulse),
    .flt_code (flt_code)
  );

  grs_wb #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_wb (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (mem_rd_en),
    .rd_slot  (rd_slot),
    .mem_rdata(mem_rdata),
    .wide     (wide),
    .base     (base),
    .flt_pulse(flt_pulse),
    .flt_code (flt_code),
    .rf_we    (rf_we),
    .rf_idx   (rf_idx),
    .rf_wdata (rf_wdata),
    .rf_wmask (rf_wmask),
    .last_wr  (wb_last),
    .sp_we    (sp_we),
    .sp_wdata (sp_wdata),
    .done     (done),
    .status   (status_e)
  );

  assign status = status_e;

  // R8: a rejected command leaves registers and stack pointer alone
  p_fault_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (done && status != 2'd0) |-> (!rf_we && !sp_we));

  // R6: an invalid command accepted while idle issues no read
  p_badop_noread_r6: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && (mode64 || lock)) |=> !mem_rd_en);
endmodule

// File: tb/tb_gpr_restore_seq.sv
`timescale 1ns/1ps
module tb_gpr_restore_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0, op32 = 1'b0, mode64 = 1'b0, lock = 1'b0;
  logic [7:0]  sp_in = '0, seg_limit = '0;
  logic        busy, mem_rd_en, rf_we, sp_we, done;
  logic [7:0]  mem_addr, sp_wdata;
  logic [31:0] mem_rdata = '0, rf_wdata;
  logic [2:0]  rf_idx;
  logic [3:0]  rf_wmask;
  logic [1:0]  status;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  gpr_restore_seq #(.ADDR_W(8), .REG_W(32)) dut (
    .clk(clk), .rst(rst), .start(start), .op32(op32), .mode64(mode64), .lock(lock),
    .sp_in(sp_in), .seg_limit(seg_limit), .busy(busy), .mem_rd_en(mem_rd_en),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .rf_we(rf_we), .rf_idx(rf_idx),
    .rf_wdata(rf_wdata), .rf_wmask(rf_wmask), .sp_we(sp_we), .sp_wdata(sp_wdata),
    .done(done), .status(status));

  function automatic logic [7:0] bt(int a);
    return 8'((((a & 255) * 37) + 11) & 255);
  endfunction

  function automatic logic [31:0] mword(int a);
    return {bt(a + 3), bt(a + 2), bt(a + 1), bt(a)};
  endfunction

  always @(posedge clk) if (mem_rd_en) mem_rdata <= mword(int'(mem_addr));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic run_cmd(int sp, int lim, bit w, bit m64, bit lk, bit poke);
    int sz, code;
    string ftag;
    logic [31:0] wd;
    sz   = w ? 4 : 2;
    code = (m64 || lk) ? 1 : (((sp > lim) || (sp + 8 * sz - 1 > lim)) ? 2 : 0);
    ftag = (code == 1 && ((sp > lim) || (sp + 8 * sz - 1 > lim))) ? "R9" :
           m64 ? "R6" : lk ? "R7" : "R8";
    @(negedge clk);
    sp_in = 8'(sp); seg_limit = 8'(lim); op32 = w; mode64 = m64; lock = lk; start = 1'b1;
    for (int i = 0; i < 14; i++) begin
      @(negedge clk);
      if (i == 0) start = 1'b0;
      if (poke && i == 3) begin start = 1'b1; sp_in = 8'(sp ^ 8'h55); op32 = ~w; end
      if (poke && i == 4) start = 1'b0;
      if (code == 0) begin
        chk("R2 rd_en", 32'(mem_rd_en), 32'(i <= 7));
        if (i <= 7) chk("R2 addr", 32'(mem_addr), 32'((sp + i * sz) & 255));
        chk("R3 we", 32'(rf_we), 32'(i >= 2 && i <= 9 && i != 5));
        if (i >= 2 && i <= 9 && i != 5) begin
          chk("R3 idx", 32'(rf_idx), 32'(9 - i));
          wd = mword(sp + (i - 2) * sz);
          if (!w) wd = {16'h0, wd[15:0]};
          chk("R4 data", rf_wdata, wd);
          chk("R4 mask", 32'(rf_wmask), w ? 32'hf : 32'h3);
        end
        chk("R11 busy", 32'(busy), 32'(i <= 9));
        chk("R5 done", 32'(done), 32'(i == 10));
        chk("R5 sp_we", 32'(sp_we), 32'(i == 10));
        if (i == 10) begin
          chk("R5 sp", 32'(sp_wdata), 32'((sp + 8 * sz) & 255));
          chk("R5 status", 32'(status), 32'd0);
        end
      end else begin
        chk({ftag, " rd_en"}, 32'(mem_rd_en), 32'd0);
        chk({ftag, " we"}, 32'(rf_we), 32'd0);
        chk({ftag, " sp_we"}, 32'(sp_we), 32'd0);
        chk({ftag, " busy"}, 32'(busy), 32'd0);
        chk({ftag, " done"}, 32'(done), 32'(i == 1));
        if (i == 1) chk({ftag, " status"}, 32'(status), 32'(code));
      end
      if (poke && i == 13) chk("R10 idle", 32'(mem_rd_en | busy | done), 32'd0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: idle outputs after reset
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 done", 32'(done), 32'd0);
    chk("R1 rd_en", 32'(mem_rd_en), 32'd0);
    chk("R1 we", 32'(rf_we), 32'd0);
    chk("R1 sp_we", 32'(sp_we), 32'd0);
    for (int w = 0; w < 2; w++)
      for (int li = 0; li < 2; li++)
        for (int sp = 0; sp < 256; sp++)
          run_cmd(sp, li == 0 ? 255 : 150, w[0], 1'b0, 1'b0, 1'b0);
    run_cmd(16, 255, 1'b1, 1'b1, 1'b0, 1'b0);   // R6
    run_cmd(16, 255, 1'b0, 1'b0, 1'b1, 1'b0);   // R7
    run_cmd(250, 100, 1'b1, 1'b1, 1'b0, 1'b0);  // R9
    run_cmd(140, 150, 1'b0, 1'b0, 1'b1, 1'b0);  // R9
    run_cmd(40, 255, 1'b1, 1'b0, 1'b0, 1'b1);   // R10
    run_cmd(7, 200, 1'b0, 1'b0, 1'b0, 1'b1);    // R10
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule